// File: doc/BRIEF.md
# Integer Execute Unit with Instruction Decode

This block is the purely combinational execute stage of a 32-bit integer pipeline. It receives the opcode, the three-bit operation field and the seven-bit extension field of an arithmetic instruction, together with two operands. For immediate forms, the second operand arrives already sign-extended from its 12 bits. The block decodes these fields and returns the 32-bit result in the same cycle.

The same unit also handles the two upper-immediate instructions. One places a 20-bit immediate in the high bits of the result. The other adds that shifted immediate to the supplied program counter. When the fields form an encoding the unit does not support, it drives a validity flag low and forces the result to zero, so that the pipeline can raise an illegal-instruction trap.

Top module: `rv_int_exec`

## Requirements
- R1: With opcode 0110011 and operation field 000, an extension field of 0000000 gives op_a + op_b and 0100000 gives op_a - op_b. Both wrap modulo 2^32.
- R2: With opcode 0010011 and operation field 000, the result is always op_a + op_b, whatever the extension field holds.
- R3: On either arithmetic opcode, operation fields 100, 110 and 111 give the bitwise XOR, OR and AND of the operands.
- R4: Operation field 001 shifts op_a left by op_b[4:0], and the upper bits of op_b are ignored. The extension field must be 0000000.
- R5: Operation field 101 shifts op_a right by op_b[4:0] on both opcodes. An extension field of 0100000 fills from the sign bit, and 0000000 fills with zeros.
- R6: Operation field 010 compares the operands as signed numbers and 011 compares them as unsigned numbers. The result is 1 when op_a is less than op_b and 0 otherwise. The immediate form of the unsigned compare treats the sign-extended immediate as unsigned.
- R7: Opcode 0110111 gives {upper_imm, 12'b0}. Opcode 0010111 gives {upper_imm, 12'b0} + pc.
- R8: Any other opcode makes the encoding unsupported. So does any extension field outside the combinations listed in R1 to R5, whether on the register opcode or on an immediate shift. An unsupported encoding gives valid = 0 and result = 0. Every supported encoding gives valid = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode | input | 7 | Instruction opcode field |
| funct3 | input | 3 | Operation field |
| funct7 | input | 7 | Extension field, instruction bits 31:25 |
| op_a | input | 32 | First source operand |
| op_b | input | 32 | Second source operand, or the sign-extended immediate |
| upper_imm | input | 20 | Upper immediate for the upper-immediate instructions |
| pc | input | 32 | Program counter of the instruction |
| result | output | 32 | Computed result, zero when the encoding is unsupported |
| valid | output | 1 | High when the encoding is supported |

## Verification
The checks in the checker module assume that every input is driven to a known value. They are skipped while any field or operand is unknown. They also assume that, on immediate forms, op_b carries the same bits 11:5 that the extension field carries, as a real instruction would. The stimulus drives all inputs from time zero and builds every immediate-shift operand so that it agrees with its extension field. Unsupported encodings are then introduced one field at a time, so that each rejection is exercised in isolation.

// File: rtl/rv_int_exec.sv
module rv_int_exec #(
  parameter int XLEN = 32,
  parameter int UIW  = 20
) (
  input  logic [6:0]      opcode,
  input  logic [2:0]      funct3,
  input  logic [6:0]      funct7,
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  input  logic [UIW-1:0]  upper_imm,
  input  logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] result,
  output logic            valid
);
  localparam int SHW = $clog2(XLEN);
  localparam int LOW = XLEN - UIW;
  localparam logic [6:0] OPC_REG = 7'b0110011;
  localparam logic [6:0] OPC_IMM = 7'b0010011;
  localparam logic [6:0] OPC_LUI = 7'b0110111;
  localparam logic [6:0] OPC_AUI = 7'b0010111;
  localparam logic [6:0] F7_BASE = 7'b0000000;
  localparam logic [6:0] F7_ALT  = 7'b0100000;

  logic            is_reg, is_imm, alt, base;
  logic [SHW-1:0]  shamt;
  logic [XLEN-1:0] upper, raw;
  logic            ok;

  assign is_reg = opcode == OPC_REG;
  assign is_imm = opcode == OPC_IMM;
  assign alt    = funct7 == F7_ALT;
  assign base   = funct7 == F7_BASE;
  assign shamt  = op_b[SHW-1:0];
  assign upper  = {upper_imm, {LOW{1'b0}}};

  always_comb begin
    raw = '0;
    ok  = 1'b0;
    if (is_reg || is_imm) begin
      unique case (funct3)
        3'b000: begin
          if (is_reg && alt) raw = op_a - op_b;
          else               raw = op_a + op_b;
          ok = is_imm || base || alt;
        end
        3'b001: begin
          raw = op_a << shamt;
          ok  = base;
        end
        3'b010: begin
          raw = {{(XLEN-1){1'b0}}, $signed(op_a) < $signed(op_b)};
          ok  = is_imm || base;
        end
        3'b011: begin
          raw = {{(XLEN-1){1'b0}}, op_a < op_b};
          ok  = is_imm || base;
        end
        3'b100: begin
          raw = op_a ^ op_b;
          ok  = is_imm || base;
        end
        3'b101: begin
          if (alt) raw = $unsigned($signed(op_a) >>> shamt);
          else     raw = op_a >> shamt;
          ok = base || alt;
        end
        3'b110: begin
          raw = op_a | op_b;
          ok  = is_imm || base;
        end
        default: begin
          raw = op_a & op_b;
          ok  = is_imm || base;
        end
      endcase
    end else if (opcode == OPC_LUI) begin
      raw = upper;
      ok  = 1'b1;
    end else if (opcode == OPC_AUI) begin
      raw = upper + pc;
      ok  = 1'b1;
    end
  end

  assign valid  = ok;
  assign result = ok ? raw : '0;
endmodule

// File: rtl/rv_int_exec_chk.sv
module rv_int_exec_chk (
  input logic [6:0]  opcode,
  input logic [2:0]  funct3,
  input logic [6:0]  funct7,
  input logic [31:0] op_a,
  input logic [31:0] op_b,
  input logic [19:0] upper_imm,
  input logic [31:0] pc,
  input logic [31:0] result,
  input logic        valid
);
  logic known;
  assign known = !$isunknown({opcode, funct3, funct7, op_a, op_b, upper_imm, pc});

  always_comb begin
    if (known) begin
      if (!valid)
        assert_zero_when_bad_R8: assert (result == 32'h0);
      if (opcode == 7'b0110011 && funct7 != 7'h00 && funct7 != 7'h20)
        assert_reg_ext_reject_R8: assert (!valid);
      if (opcode == 7'b0010011 && funct3 == 3'b000)
        assert_addi_accepted_R2: assert (valid && result == op_a + op_b);
      if (opcode == 7'b0110111)
        assert_lui_low_clear_R7: assert (valid && result[11:0] == 12'h0);
      if (valid && (opcode == 7'b0110011 || opcode == 7'b0010011) && funct3[2:1] == 2'b01)
        assert_compare_bit_R6: assert (result[31:1] == 31'h0);
      if (valid && funct3 == 3'b101 && funct7 == 7'h20 && op_a[31])
        assert_sign_fill_R5: assert (result[31]);
    end
  end
endmodule

bind rv_int_exec rv_int_exec_chk u_chk (
  .opcode(opcode), .funct3(funct3), .funct7(funct7), .op_a(op_a), .op_b(op_b),
  .upper_imm(upper_imm), .pc(pc), .result(result), .valid(valid)
);

// File: tb/tb_rv_int_exec.sv
module tb_rv_int_exec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  opcode = '0;
  logic [2:0]  funct3 = '0;
  logic [6:0]  funct7 = '0;
  logic [31:0] op_a = '0, op_b = '0, pc = '0;
  logic [19:0] upper_imm = '0;
  logic [31:0] result;
  logic        valid;

  int total = 0;
  int bad = 0;
  logic [32:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  rv_int_exec dut (
    .opcode(opcode), .funct3(funct3), .funct7(funct7), .op_a(op_a), .op_b(op_b),
    .upper_imm(upper_imm), .pc(pc), .result(result), .valid(valid)
  );

  localparam logic [6:0] RR = 7'h33, RI = 7'h13, LU = 7'h37, AU = 7'h17;

  task automatic drive(input logic [6:0] o, input logic [2:0] f3, input logic [6:0] f7,
                       input logic [31:0] a, input logic [31:0] b, input logic [19:0] ui,
                       input logic [31:0] p, input logic [31:0] er, input logic ev,
                       input string tag);
    @(posedge clk);
    #1;
    opcode = o; funct3 = f3; funct7 = f7; op_a = a; op_b = b; upper_imm = ui; pc = p;
    exp_q.push_back({ev, er});
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (rst_n && exp_q.size() > 0) begin
      logic [32:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if ({valid, result} !== e) begin
        bad++;
        $display("FAIL %s: got valid=%0b result=%08h, expected valid=%0b result=%08h",
                 t, valid, result, e[32], e[31:0]);
      end
    end
  end

  initial begin
    #10000;
    bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    total++;
    if (valid !== 1'b0 || result !== 32'h0) begin
      bad++;
      $display("FAIL R8 reset: got valid=%0b result=%08h, expected valid=0 result=00000000", valid, result);
    end
    rst_n = 1'b1;
    drive(RR, 3'b000, 7'h00, 32'd5, 32'd7, 20'h0, 32'h0, 32'd12, 1'b1, "R1 add");
    drive(RR, 3'b000, 7'h20, 32'd5, 32'd7, 20'h0, 32'h0, 32'hFFFFFFFE, 1'b1, "R1 sub");
    drive(RR, 3'b000, 7'h00, 32'hFFFFFFFF, 32'd1, 20'h0, 32'h0, 32'h0, 1'b1, "R1 add wrap");
    drive(RI, 3'b000, 7'h7F, 32'd10, 32'hFFFFFFFF, 20'h0, 32'h0, 32'd9, 1'b1, "R2 addi -1");
    drive(RI, 3'b000, 7'h60, 32'd100, 32'hFFFFFC00, 20'h0, 32'h0, 32'hFFFFFC64, 1'b1, "R2 addi not sub");
    drive(RR, 3'b100, 7'h00, 32'hF0F0F0F0, 32'h0FF00FF0, 20'h0, 32'h0, 32'hFF00FF00, 1'b1, "R3 xor");
    drive(RR, 3'b110, 7'h00, 32'h12340000, 32'h00005678, 20'h0, 32'h0, 32'h12345678, 1'b1, "R3 or");
    drive(RI, 3'b111, 7'h00, 32'hDEADBEEF, 32'h000000FF, 20'h0, 32'h0, 32'h000000EF, 1'b1, "R3 andi");
    drive(RR, 3'b001, 7'h00, 32'd1, 32'h00000024, 20'h0, 32'h0, 32'h00000010, 1'b1, "R4 sll low5");
    drive(RI, 3'b001, 7'h00, 32'd1, 32'd31, 20'h0, 32'h0, 32'h80000000, 1'b1, "R4 slli 31");
    drive(RR, 3'b101, 7'h20, 32'h80000000, 32'd4, 20'h0, 32'h0, 32'hF8000000, 1'b1, "R5 sra");
    drive(RR, 3'b101, 7'h00, 32'h80000000, 32'd4, 20'h0, 32'h0, 32'h08000000, 1'b1, "R5 srl");
    drive(RI, 3'b101, 7'h20, 32'h80000010, 32'h00000408, 20'h0, 32'h0, 32'hFF800000, 1'b1, "R5 srai");
    drive(RI, 3'b101, 7'h00, 32'hFFFF0000, 32'd8, 20'h0, 32'h0, 32'h00FFFF00, 1'b1, "R5 srli");
    drive(RR, 3'b101, 7'h20, 32'hFFFFFFF0, 32'hFFFFFFE1, 20'h0, 32'h0, 32'hFFFFFFF8, 1'b1, "R5 sra low5");
    drive(RR, 3'b010, 7'h00, 32'hFFFFFFFF, 32'd1, 20'h0, 32'h0, 32'd1, 1'b1, "R6 slt signed");
    drive(RR, 3'b011, 7'h00, 32'hFFFFFFFF, 32'd1, 20'h0, 32'h0, 32'd0, 1'b1, "R6 sltu unsigned");
    drive(RI, 3'b010, 7'h00, 32'd5, 32'd5, 20'h0, 32'h0, 32'd0, 1'b1, "R6 slti equal");
    drive(RI, 3'b011, 7'h7F, 32'd5, 32'hFFFFFFFF, 20'h0, 32'h0, 32'd1, 1'b1, "R6 sltiu");
    drive(LU, 3'b000, 7'h00, 32'h0, 32'h0, 20'hABCDE, 32'h0, 32'hABCDE000, 1'b1, "R7 lui");
    drive(AU, 3'b000, 7'h00, 32'h0, 32'h0, 20'h00001, 32'h00000100, 32'h00001100, 1'b1, "R7 auipc");
    drive(AU, 3'b000, 7'h00, 32'h0, 32'h0, 20'hFFFFF, 32'h00002000, 32'h00001000, 1'b1, "R7 auipc wrap");
    drive(7'h03, 3'b000, 7'h00, 32'd5, 32'd7, 20'h1, 32'h4, 32'h0, 1'b0, "R8 bad opcode");
    drive(RR, 3'b001, 7'h20, 32'd1, 32'd1, 20'h0, 32'h0, 32'h0, 1'b0, "R8 sll alt");
    drive(RR, 3'b000, 7'h01, 32'd5, 32'd7, 20'h0, 32'h0, 32'h0, 1'b0, "R8 reg ext");
    drive(RI, 3'b001, 7'h20, 32'd1, 32'h00000401, 20'h0, 32'h0, 32'h0, 1'b0, "R8 slli alt");
    drive(RI, 3'b101, 7'h10, 32'hFF, 32'h00000201, 20'h0, 32'h0, 32'h0, 1'b0, "R8 srai ext");
    drive(RR, 3'b111, 7'h20, 32'hFF, 32'hFF, 20'h0, 32'h0, 32'h0, 1'b0, "R8 and alt");
    @(posedge clk);
    @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule